// File: doc/BRIEF.md
# Multi-Mode Load Sequencer

This block is the controller and a minimal single-bus datapath for a small processor that executes one kind of work: loading a 16-bit operand from a word-addressed memory into one of four general registers. Each instruction is fetched through a program counter, a memory address register (MAR), a memory data register (MDR) and an instruction register (IR). A numbered step counter then drives one-hot-style control strobes onto a shared internal bus. The operand address is resolved in one of three ways. In direct mode it is the address field of the instruction. In memory-indirect mode it is the low byte of the word stored at that address, which costs a second chained memory read. In register-indirect mode it is the low byte of a source register.

Memory is reached through a read request that stays high until the memory raises its function-complete input, for a latency of any number of cycles. The step counter waits in every read step until that input arrives. The number of steps depends on the addressing mode. A one-cycle done strobe marks the step that retires the instruction, and the counter returns to step 1 on the following cycle.

Instruction word layout: bits [15:12] opcode (4'h1 means load), [11:10] mode (00 direct, 01 memory-indirect, 10 register-indirect, 11 reserved), [9:8] destination register, [7:0] address field. In register-indirect mode the source register index is taken from bits [1:0] of the address field.

Top module: `ldseq_top`

## Requirements
- R1: A synchronous active-low reset clears PC, IR, MAR, MDR and all four registers, sets the step to 1 and leaves read request and done low.
- R2: Steps 1 to 3 fetch the instruction: step 1 copies PC into MAR and increments PC, step 2 reads memory at that address, step 3 moves the read word into IR.
- R3: Whenever the read request is high and the completion input is low, the step, the request and the memory address stay unchanged on the next cycle; MDR changes only on a cycle with both request and completion high.
- R4: In direct mode (mode 00) the word at the address field is written into the destination register; the instruction takes 4 + 2·L cycles for a memory latency of L cycles per read.
- R5: In memory-indirect mode (mode 01) the low byte of the word at the address field is used as the operand address, and that operand is written into the destination register; the instruction takes 5 + 3·L cycles and the step never exceeds 8.
- R6: In register-indirect mode (mode 10) the low byte of the source register (index in bits [1:0]) is the operand address; the instruction takes 4 + 2·L cycles.
- R7: Done is high for exactly one cycle, on the step that retires the instruction, and the step is 1 on the next cycle; a register is written only in a cycle where done is high.
- R8: An opcode other than 4'h1, or mode 11, retires after step 3 in 2 + L cycles and leaves every register unchanged.
- R9: PC increases by exactly one per instruction, in step 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rd | output | 1 | Memory read request, held until completion |
| mem_addr | output | 8 | Memory word address (MAR contents) |
| mem_rdata | input | 16 | Memory read data, valid with completion |
| mem_mfc | input | 1 | Memory function complete |
| done | output | 1 | One-cycle strobe on the retiring step |
| step_o | output | 4 | Current control step, 1 to 8 |
| pc_o | output | 8 | Program counter |
| regs_o | output | 64 | The four general registers, register i in bits [16i+15:16i] |
| ctl_pc_out | output | 1 | PC drives the bus |
| ctl_ir_out | output | 1 | IR address field drives the bus |
| ctl_mdr_out | output | 1 | MDR drives the bus |
| ctl_reg_out | output | 1 | Source register drives the bus |
| ctl_mar_in | output | 1 | MAR loads from the bus |
| ctl_ir_in | output | 1 | IR loads from the bus |
| ctl_reg_in | output | 1 | Destination register loads from the bus |
| ctl_pc_inc | output | 1 | PC increments |

## Verification
The embedded properties watch, on every cycle, the read-wait rule (step, request and address frozen until completion, MDR untouched otherwise), the one-cycle done strobe with its return to step 1, the limit of eight steps, register writes only on retiring load steps, and the single-step PC increment. Whether the right operand lands in the right register, the mode-dependent cycle counts under varying latency, the chained pointer resolution and the no-op handling of foreign opcodes and the reserved mode can only be shown by the bench's instruction streams, which compare registers, PC and cycle counts against a reference model.

// File: rtl/ldseq_pkg.sv
`timescale 1ns/1ps
package ldseq_pkg;
    localparam int LDSEQ_DATA_W = 16;
    localparam int LDSEQ_ADDR_W = 8;
    localparam int LDSEQ_NREG   = 4;
    localparam int LDSEQ_STEP_W = 4;

    localparam logic [3:0] OP_LOAD = 4'h1;

    typedef enum logic [1:0] {
        MODE_DIR    = 2'b00,
        MODE_MEMIND = 2'b01,
        MODE_REGIND = 2'b10,
        MODE_RSVD   = 2'b11
    } mode_e;

    typedef struct packed {
        logic pc_out;
        logic ir_out;
        logic mdr_out;
        logic reg_out;
        logic mar_in;
        logic ir_in;
        logic reg_in;
        logic pc_inc;
        logic rd;
        logic done;
    } ctl_t;
endpackage

// File: rtl/ldseq_regfile.sv
`timescale 1ns/1ps
module ldseq_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 4,
    localparam int IW  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [IW-1:0]    raddr,
    output logic [DW-1:0]    rdata,
    output logic [NREG*DW-1:0] flat
);
    logic [DW-1:0] r_d [NREG];
    logic [DW-1:0] r_q [NREG];

    always_comb begin
        r_d = r_q;
        if (we) r_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) r_q[i] <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata = r_q[raddr];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign flat[g*DW +: DW] = r_q[g];
    end
endmodule

// File: rtl/ldseq_ctrl.sv
`timescale 1ns/1ps
module ldseq_ctrl
    import ldseq_pkg::*;
#(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ir_op,
    input  logic [1:0]        ir_mode,
    input  logic [3:0]        fetch_op,
    input  logic [1:0]        fetch_mode,
    input  logic              mfc,
    output ctl_t              ctl,
    output logic [STEP_W-1:0] step
);
    localparam logic [STEP_W-1:0] ST_PC2MAR   = STEP_W'(1);
    localparam logic [STEP_W-1:0] ST_IFETCH   = STEP_W'(2);
    localparam logic [STEP_W-1:0] ST_IR_LOAD  = STEP_W'(3);
    localparam logic [STEP_W-1:0] ST_ADDR     = STEP_W'(4);
    localparam logic [STEP_W-1:0] ST_RD_A     = STEP_W'(5);
    localparam logic [STEP_W-1:0] ST_AFTER_A  = STEP_W'(6);
    localparam logic [STEP_W-1:0] ST_RD_B     = STEP_W'(7);
    localparam logic [STEP_W-1:0] ST_WRITE_B  = STEP_W'(8);

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic is_load(input logic [3:0] op, input logic [1:0] mode);
        return (op == OP_LOAD) && (mode != MODE_RSVD);
    endfunction

    always_comb begin
        s_d = s_q;
        ctl = '0;
        case (s_q.step)
            ST_PC2MAR: begin
                ctl.pc_out = 1'b1;
                ctl.mar_in = 1'b1;
                ctl.pc_inc = 1'b1;
                s_d.step   = ST_IFETCH;
            end
            ST_IFETCH: begin
                ctl.rd = 1'b1;
                if (mfc) s_d.step = ST_IR_LOAD;
            end
            ST_IR_LOAD: begin
                ctl.mdr_out = 1'b1;
                ctl.ir_in   = 1'b1;
                if (is_load(fetch_op, fetch_mode)) begin
                    s_d.step = ST_ADDR;
                end else begin
                    ctl.done = 1'b1;
                    s_d.step = ST_PC2MAR;
                end
            end
            ST_ADDR: begin
                ctl.mar_in = 1'b1;
                if (ir_mode == MODE_REGIND) ctl.reg_out = 1'b1;
                else                        ctl.ir_out  = 1'b1;
                s_d.step = ST_RD_A;
            end
            ST_RD_A: begin
                ctl.rd = 1'b1;
                if (mfc) s_d.step = ST_AFTER_A;
            end
            ST_AFTER_A: begin
                ctl.mdr_out = 1'b1;
                if (ir_mode == MODE_MEMIND) begin
                    ctl.mar_in = 1'b1;
                    s_d.step   = ST_RD_B;
                end else begin
                    ctl.reg_in = 1'b1;
                    ctl.done   = 1'b1;
                    s_d.step   = ST_PC2MAR;
                end
            end
            ST_RD_B: begin
                ctl.rd = 1'b1;
                if (mfc) s_d.step = ST_WRITE_B;
            end
            ST_WRITE_B: begin
                ctl.mdr_out = 1'b1;
                ctl.reg_in  = 1'b1;
                ctl.done    = 1'b1;
                s_d.step    = ST_PC2MAR;
            end
            default: s_d.step = ST_PC2MAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.step <= ST_PC2MAR;
        else        s_q <= s_d;
    end

    assign step = s_q.step;

    AST_WAIT_HOLDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.rd && !mfc) |=> (step == $past(step)) && ctl.rd); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.done |=> !ctl.done); // R7
    AST_DONE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.done |=> step == ST_PC2MAR); // R7
    AST_WRITE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.reg_in |-> ctl.done); // R7
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (step >= ST_PC2MAR) && (step <= ST_WRITE_B)); // R5
endmodule

// File: rtl/ldseq_top.sv
`timescale 1ns/1ps
module ldseq_top
    import ldseq_pkg::*;
#(
    parameter int DW     = LDSEQ_DATA_W,
    parameter int AW     = LDSEQ_ADDR_W,
    parameter int NREG   = LDSEQ_NREG,
    parameter int STEP_W = LDSEQ_STEP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 mem_rd,
    output logic [AW-1:0]        mem_addr,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_mfc,
    output logic                 done,
    output logic [STEP_W-1:0]    step_o,
    output logic [AW-1:0]        pc_o,
    output logic [NREG*DW-1:0]   regs_o,
    output logic                 ctl_pc_out,
    output logic                 ctl_ir_out,
    output logic                 ctl_mdr_out,
    output logic                 ctl_reg_out,
    output logic                 ctl_mar_in,
    output logic                 ctl_ir_in,
    output logic                 ctl_reg_in,
    output logic                 ctl_pc_inc
);
    localparam int RIW      = $clog2(NREG);
    localparam int OP_LSB   = DW - 4;
    localparam int MODE_LSB = DW - 6;
    localparam int DST_LSB  = DW - 8;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [DW-1:0] ir;
        logic [AW-1:0] mar;
        logic [DW-1:0] mdr;
    } dp_t;

    dp_t           dp_d, dp_q;
    ctl_t          ctl;
    logic [DW-1:0] bus;
    logic [DW-1:0] rf_rdata;

    ldseq_ctrl #(.STEP_W(STEP_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ir_op      (dp_q.ir[OP_LSB +: 4]),
        .ir_mode    (dp_q.ir[MODE_LSB +: 2]),
        .fetch_op   (dp_q.mdr[OP_LSB +: 4]),
        .fetch_mode (dp_q.mdr[MODE_LSB +: 2]),
        .mfc        (mem_mfc),
        .ctl        (ctl),
        .step       (step_o)
    );

    ldseq_regfile #(.DW(DW), .NREG(NREG)) i_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl.reg_in),
        .waddr (dp_q.ir[DST_LSB +: RIW]),
        .wdata (bus),
        .raddr (dp_q.ir[RIW-1:0]),
        .rdata (rf_rdata),
        .flat  (regs_o)
    );

    always_comb begin
        bus = '0;
        if (ctl.pc_out)       bus[AW-1:0] = dp_q.pc;
        else if (ctl.ir_out)  bus[AW-1:0] = dp_q.ir[AW-1:0];
        else if (ctl.mdr_out) bus = dp_q.mdr;
        else if (ctl.reg_out) bus = rf_rdata;
    end

    always_comb begin
        dp_d = dp_q;
        if (ctl.mar_in)          dp_d.mar = bus[AW-1:0];
        if (ctl.pc_inc)          dp_d.pc  = dp_q.pc + 1'b1;
        if (ctl.ir_in)           dp_d.ir  = bus;
        if (ctl.rd && mem_mfc)   dp_d.mdr = mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign mem_rd      = ctl.rd;
    assign mem_addr    = dp_q.mar;
    assign done        = ctl.done;
    assign pc_o        = dp_q.pc;
    assign ctl_pc_out  = ctl.pc_out;
    assign ctl_ir_out  = ctl.ir_out;
    assign ctl_mdr_out = ctl.mdr_out;
    assign ctl_reg_out = ctl.reg_out;
    assign ctl_mar_in  = ctl.mar_in;
    assign ctl_ir_in   = ctl.ir_in;
    assign ctl_reg_in  = ctl.reg_in;
    assign ctl_pc_inc  = ctl.pc_inc;

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_mfc) |=> $stable(mem_addr)); // R3
    AST_MDR_ONLY_ON_MFC: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_mfc) |=> $stable(dp_q.mdr)); // R3
    AST_PC_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_inc |=> pc_o == $past(pc_o) + 1'b1); // R9
    AST_PC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.pc_inc |=> $stable(pc_o)); // R9
    AST_WRITE_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.reg_in |-> (dp_q.ir[OP_LSB +: 4] == OP_LOAD)); // R8
endmodule

// File: tb/test_ldseq_top.sv
`timescale 1ns/1ps
module test_ldseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd;
    logic [7:0]  mem_addr;
    logic [15:0] mem_rdata;
    logic        mem_mfc;
    logic        done;
    logic [3:0]  step_o;
    logic [7:0]  pc_o;
    logic [63:0] regs_o;
    logic c_pc_out, c_ir_out, c_mdr_out, c_reg_out, c_mar_in, c_ir_in, c_reg_in, c_pc_inc;

    always #2.5 clk = ~clk;

    ldseq_top i_ldseq_top (
        .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_mfc(mem_mfc), .done(done), .step_o(step_o),
        .pc_o(pc_o), .regs_o(regs_o),
        .ctl_pc_out(c_pc_out), .ctl_ir_out(c_ir_out), .ctl_mdr_out(c_mdr_out),
        .ctl_reg_out(c_reg_out), .ctl_mar_in(c_mar_in), .ctl_ir_in(c_ir_in),
        .ctl_reg_in(c_reg_in), .ctl_pc_inc(c_pc_inc)
    );

    logic [15:0] mem [256];
    logic [15:0] er  [4];
    logic [7:0]  epc;
    int lat = 1;
    int nchk = 0;
    int nerr = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: completion after lat cycles of held request
    initial begin
        int mcnt;
        mcnt = 0;
        mem_mfc = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mcnt = 0;
                mem_mfc = 1'b0;
            end else if (mem_rd && !mem_mfc) begin
                if (mcnt >= lat - 1) begin
                    mem_mfc = 1'b1;
                    mem_rdata = mem[mem_addr];
                    mcnt = 0;
                end else begin
                    mcnt++;
                end
            end else begin
                mem_mfc = 1'b0;
                mcnt = 0;
            end
        end
    end

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [1:0] mode,
                                       input logic [1:0] dst, input logic [7:0] fld);
        return {op, mode, dst, fld};
    endfunction

    // runs one instruction starting at the current negedge (cycle 1 of it)
    task automatic exec(input logic [15:0] w, input int l);
        logic [3:0] op;
        logic [1:0] mode, dst;
        logic [7:0] a, fetch_at;
        bit ld;
        int exp_cyc, cnt;
        bit seen2;
        string tag;
        lat = l;
        mem[epc] = w;
        fetch_at = epc;
        op = w[15:12]; mode = w[11:10]; dst = w[9:8];
        ld = (op == 4'h1) && (mode != 2'b11);
        a = w[7:0];
        if (!ld) begin
            exp_cyc = 2 + l; tag = "R8";
        end else if (mode == 2'b00) begin
            exp_cyc = 4 + 2*l; tag = "R4";
        end else if (mode == 2'b01) begin
            a = mem[w[7:0]][7:0]; exp_cyc = 5 + 3*l; tag = "R5";
        end else begin
            a = er[w[1:0]][7:0]; exp_cyc = 4 + 2*l; tag = "R6";
        end
        if (ld) er[dst] = mem[a];
        epc = epc + 8'd1;
        cnt = 1;
        seen2 = 0;
        while (!done && cnt < 200) begin
            @(negedge clk);
            cnt++;
            if (step_o == 4'd2 && !seen2) begin
                seen2 = 1;
                chk(mem_addr == fetch_at && mem_rd, "R2 fetch address", {mem_rd, mem_addr}, {1'b1, fetch_at});
            end
        end
        chk(cnt == exp_cyc, {tag, " cycle count"}, cnt, exp_cyc);
        @(negedge clk);
        chk(done == 1'b0 && step_o == 4'd1, "R7 done pulse / restart", {done, step_o}, 5'h01);
        chk(pc_o == epc, "R9 pc advance", pc_o, epc);
        for (int i = 0; i < 4; i++)
            chk(regs_o[i*16 +: 16] == er[i], {tag, " register contents"}, regs_o[i*16 +: 16], er[i]);
    endtask

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 128; i++) mem[i] = '0;
        for (int i = 128; i < 256; i++) mem[i] = {8'($urandom), 1'b1, 7'($urandom)};
        for (int i = 0; i < 4; i++) er[i] = '0;
        epc = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(regs_o == '0, "R1 registers cleared", regs_o, 64'h0);
        chk(pc_o == 8'h00 && step_o == 4'd1, "R1 pc/step", {pc_o, step_o}, 12'h001);
        chk(!done && !mem_rd && mem_addr == 8'h00, "R1 outputs idle", {done, mem_rd, mem_addr}, 10'h0);
        // directed corners
        exec(mk(4'h1, 2'b00, 2'd1, 8'h90), 1);   // R4 direct, fastest memory
        exec(mk(4'h1, 2'b01, 2'd2, 8'hA3), 4);   // R5 chained reads, slowest memory
        exec(mk(4'h1, 2'b10, 2'd3, 8'hC1), 2);   // R6 source register 1
        exec(mk(4'h0, 2'b00, 2'd1, 8'h85), 3);   // R8 foreign opcode
        exec(mk(4'h1, 2'b11, 2'd2, 8'h87), 1);   // R8 reserved mode
        exec(mk(4'h1, 2'b10, 2'd2, 8'h82), 4);   // R6 source equals destination
        exec(mk(4'h1, 2'b01, 2'd0, 8'hFF), 3);   // R5 top of memory
        // random stream
        for (int n = 0; n < 45; n++) begin
            logic [3:0] op;
            op = ($urandom % 6 == 0) ? 4'(($urandom % 14) + 2) : 4'h1;
            exec(mk(op, 2'($urandom), 2'($urandom), {1'b1, 7'($urandom)}), int'($urandom % 4) + 1);
        end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule